// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the serial-peripheral slave front end of a serial flash device. It samples the chip-select, serial clock, serial input and pause pins on the chip's own clock and finds the serial clock edges. It works with a serial clock that idles low (mode 0) or high (mode 3). Bits are taken from the serial input on rising edges, most significant bit first. The first byte of every selection is decoded as a command. The block then collects address and data bytes and drives the serial output with an enable for the pad tri-state. Its results go to the protection, program and erase logic as one-cycle command, address, write and read-request pulses. It does not contain the memory array or the program/erase timer. It only receives a busy level from that timer.

A byte that is not a known command puts the interface into a lockout. In lockout, nothing is decoded and the output stays disabled until the next selection. The pause pin suspends a transfer without losing its place. It only takes effect, and is only released, while the serial clock is low. Every serial clock phase must last at least three cycles of `clk`.

Top module: `spi_flash_front`

## Requirements
- R1: After reset, and while `cs_n` is high, `so_oe` is low and no strobe (`cmd_strobe`, `addr_valid`, `wr_valid`, `rd_req`) is asserted.
- R2: The first byte after `cs_n` falls is taken MSB first in both modes and decoded as follows. 0x06 gives id 1 (write enable), 0x04 gives id 2 (write disable), 0x05 gives id 3 (status read), 0x01 gives id 4 (status write), 0x03 gives id 5 (read), 0x02 gives id 6 (program), 0x20 gives id 7 (sector erase), 0xD8 gives id 8 (block erase) and 0xC7 gives id 9 (chip erase). Each decoded command raises `cmd_strobe` for one cycle, with `cmd_id` holding the id.
- R3: Any other first byte raises no strobe, and `so_oe` stays low until `cs_n` rises and falls again. The next selection then decodes normally.
- R4: While `busy` is high, only the status-read command (0x05) is accepted. Every other command is treated as an invalid byte, as in R3.
- R5: Read, program and both addressed erases take three address bytes, MSB first. After the third byte, `addr_valid` pulses once, with `addr` holding the address masked to its low `MEM_AW` bits.
- R6: A read pulses `rd_req` with `addr` set to the start address. It then pulses `rd_req` again with `addr + 1` after each output byte. The address wraps from 2^`MEM_AW`-1 to 0. The `tx_byte` value present at the falling edge that starts each output byte is sent on `so`, MSB first, changing on falling serial clock edges.
- R7: In a program, each data byte gives one `wr_valid` pulse with the byte on `wr_data`. The first byte goes to the start address and each later byte to the next address, with the same wrap as R6.
- R8: A status write gives exactly one `wr_valid` pulse, with the first data byte. Later bytes in the same selection are ignored.
- R9: A status read sends `status_in` on `so` repeatedly, one full byte per 8 clocks, with `so_oe` high.
- R10: `hold_n` low while the serial clock is low pauses the transfer. During the pause, `so_oe` is low and serial clock edges and `si` are ignored. Releasing `hold_n` has an effect only once the serial clock is low. The transfer then continues at the same bit.
- R11: `cs_n` high at any point returns the block to waiting for a command byte. Any partial byte or partial address is discarded.
- R12: `so_oe` is high only during the output phase of a read or status read. Commands without output leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, which samples all serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| busy | input | 1 | Program/erase cycle running |
| status_in | input | 8 | Status byte sent by status read |
| tx_byte | input | 8 | Array byte for the current `addr` |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad |
| cmd_strobe | output | 1 | Command decoded pulse |
| cmd_id | output | 4 | Decoded command id (see R2) |
| addr_valid | output | 1 | Address complete pulse |
| addr | output | 8*ADDR_BYTES | Current byte address |
| wr_valid | output | 1 | Data byte received pulse |
| wr_data | output | 8 | Received data byte |
| rd_req | output | 1 | Next read byte request pulse |

## Verification
The bench builds the block with `MEM_AW` = 12 and `ADDR_BYTES` = 3. This makes address wrap reachable in a few bytes, for both read streaming and program. All 256 first-byte values are swept in mode 0 and in mode 3, so every decode and every lockout case is checked directly. The busy filter is swept over all nine commands. A pause is inserted inside a read byte, with release tried during a high clock phase, to show that the bit position survives the pause.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [3:0] {
    CMD_NONE   = 4'd0,
    CMD_WREN   = 4'd1,
    CMD_WRDI   = 4'd2,
    CMD_RDSR   = 4'd3,
    CMD_WRSR   = 4'd4,
    CMD_READ   = 4'd5,
    CMD_PROG   = 4'd6,
    CMD_SERASE = 4'd7,
    CMD_BERASE = 4'd8,
    CMD_CERASE = 4'd9,
    CMD_BAD    = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_DONE, ST_LOCK
  } st_e;

  function automatic cmd_e op_decode(input logic [7:0] op);
    case (op)
      8'h06:   op_decode = CMD_WREN;
      8'h04:   op_decode = CMD_WRDI;
      8'h05:   op_decode = CMD_RDSR;
      8'h01:   op_decode = CMD_WRSR;
      8'h03:   op_decode = CMD_READ;
      8'h02:   op_decode = CMD_PROG;
      8'h20:   op_decode = CMD_SERASE;
      8'hD8:   op_decode = CMD_BERASE;
      8'hC7:   op_decode = CMD_CERASE;
      default: op_decode = CMD_BAD;
    endcase
  endfunction

  function automatic st_e after_opcode(input cmd_e c);
    case (c)
      CMD_READ, CMD_PROG, CMD_SERASE, CMD_BERASE: after_opcode = ST_ADDR;
      CMD_WRSR: after_opcode = ST_WDATA;
      CMD_RDSR: after_opcode = ST_RDATA;
      default:  after_opcode = ST_DONE;
    endcase
  endfunction

endpackage

// File: rtl/sfe_pins.sv
module sfe_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic held
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_q <= sck;
      if (cs_n)      held <= 1'b0;
      else if (!sck) held <= !hold_n;
    end
  end

  assign sel      = !cs_n;
  assign sck_rise = sel && !held && sck && !sck_q;
  assign sck_fall = sel && !held && !sck && sck_q;
endmodule

// File: rtl/sfe_shift.sv
module sfe_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       si,
  input  logic       out_phase,
  input  logic [7:0] tx_byte,
  output logic [2:0] bit_cnt,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       so_bit,
  output logic       out_en
);
  logic [7:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
      tx_sr     <= '0;
      so_bit    <= 1'b0;
      out_en    <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
        out_en  <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_byte   <= {rx_byte[6:0], si};
          bit_cnt   <= bit_cnt + 3'd1;
          byte_done <= (bit_cnt == 3'd7);
        end
        if (sck_fall) begin
          if (bit_cnt == 3'd0 && out_phase) begin
            so_bit <= tx_byte[7];
            tx_sr  <= {tx_byte[6:0], 1'b0};
            out_en <= 1'b1;
          end else begin
            so_bit <= tx_sr[7];
            tx_sr  <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int MEM_AW     = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    byte_done,
  input  logic [7:0]              rx_byte,
  input  logic                    busy,
  output logic                    out_phase,
  output logic                    locked,
  output cmd_e                    cur,
  output logic                    cmd_strobe,
  output logic                    addr_valid,
  output logic [8*ADDR_BYTES-1:0] addr_q,
  output logic                    wr_valid,
  output logic [7:0]              wr_data,
  output logic                    rd_req
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam int CW = $clog2(ADDR_BYTES) + 1;

  st_e          state;
  cmd_e         dec;
  logic [CW-1:0] cnt;
  logic         first;
  logic [AW-1:0] abuf;
  logic [AW-1:0] abuf_nx;

  function automatic logic [AW-1:0] mask_addr(input logic [AW-1:0] a);
    mask_addr = '0;
    mask_addr[MEM_AW-1:0] = a[MEM_AW-1:0];
  endfunction

  function automatic logic [AW-1:0] inc_addr(input logic [AW-1:0] a);
    inc_addr = '0;
    inc_addr[MEM_AW-1:0] = a[MEM_AW-1:0] + 1'b1;
  endfunction

  assign dec       = op_decode(rx_byte);
  assign abuf_nx   = {abuf[AW-9:0], rx_byte};
  assign out_phase = (state == ST_RDATA);
  assign locked    = (state == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OPC;  cur <= CMD_NONE;  cnt <= '0;  first <= 1'b1;
      abuf <= '0;  addr_q <= '0;  wr_data <= '0;
      cmd_strobe <= 1'b0;  addr_valid <= 1'b0;  wr_valid <= 1'b0;  rd_req <= 1'b0;
    end else begin
      cmd_strobe <= 1'b0;  addr_valid <= 1'b0;  wr_valid <= 1'b0;  rd_req <= 1'b0;
      if (!sel) begin
        state <= ST_OPC;  cnt <= '0;  first <= 1'b1;
      end else if (byte_done) begin
        case (state)
          ST_OPC: begin
            if (dec == CMD_BAD || (busy && dec != CMD_RDSR)) begin
              state <= ST_LOCK;
            end else begin
              cur        <= dec;
              cmd_strobe <= 1'b1;
              state      <= after_opcode(dec);
            end
          end
          ST_ADDR: begin
            abuf <= abuf_nx;
            cnt  <= cnt + 1'b1;
            if (cnt == CW'(ADDR_BYTES - 1)) begin
              cnt        <= '0;
              addr_q     <= mask_addr(abuf_nx);
              addr_valid <= 1'b1;
              case (cur)
                CMD_READ: begin state <= ST_RDATA; rd_req <= 1'b1; end
                CMD_PROG: state <= ST_WDATA;
                default:  state <= ST_DONE;
              endcase
            end
          end
          ST_WDATA: begin
            wr_data  <= rx_byte;
            wr_valid <= 1'b1;
            if (cur == CMD_WRSR) begin
              state <= ST_DONE;
            end else begin
              first <= 1'b0;
              if (!first) addr_q <= inc_addr(addr_q);
            end
          end
          ST_RDATA: begin
            if (cur == CMD_READ) begin
              addr_q <= inc_addr(addr_q);
              rd_req <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import sfe_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int MEM_AW     = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sck,
  input  logic                    cs_n,
  input  logic                    si,
  input  logic                    hold_n,
  input  logic                    busy,
  input  logic [7:0]              status_in,
  input  logic [7:0]              tx_byte,
  output logic                    so,
  output logic                    so_oe,
  output logic                    cmd_strobe,
  output logic [3:0]              cmd_id,
  output logic                    addr_valid,
  output logic [8*ADDR_BYTES-1:0] addr,
  output logic                    wr_valid,
  output logic [7:0]              wr_data,
  output logic                    rd_req
);
  logic       sel, sck_rise, sck_fall, held;
  logic [2:0] bit_cnt;
  logic       byte_done, so_bit, out_en, out_phase, locked;
  logic [7:0] rx_byte, tx_pick;
  cmd_e       cur;

  sfe_pins u_pins (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .held(held)
  );

  assign tx_pick = (cur == CMD_RDSR) ? status_in : tx_byte;

  sfe_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si(si), .out_phase(out_phase), .tx_byte(tx_pick),
    .bit_cnt(bit_cnt), .byte_done(byte_done), .rx_byte(rx_byte),
    .so_bit(so_bit), .out_en(out_en)
  );

  sfe_ctrl #(.ADDR_BYTES(ADDR_BYTES), .MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .byte_done(byte_done),
    .rx_byte(rx_byte), .busy(busy), .out_phase(out_phase), .locked(locked),
    .cur(cur), .cmd_strobe(cmd_strobe), .addr_valid(addr_valid),
    .addr_q(addr), .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req)
  );

  assign cmd_id = cur;
  assign so_oe  = sel && out_en && !held;
  assign so     = so_oe ? so_bit : 1'b0;
endmodule

// File: rtl/sfe_chk.sv
module sfe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       busy,
  input logic       so_oe,
  input logic       cmd_strobe,
  input logic [3:0] cmd_id,
  input logic       addr_valid,
  input logic       wr_valid,
  input logic       held,
  input logic       locked,
  input logic [2:0] bit_cnt
);
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!so_oe && !cmd_strobe && !addr_valid && !wr_valid)); // R3

  AST_BUSY_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> (!$past(busy) || cmd_id == 4'd3)); // R4

  AST_HOLD_KEEPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(bit_cnt)); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_strobe, addr_valid, wr_valid})); // R2

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_cnt == 3'd0 && !locked && !so_oe)); // R11
endmodule

bind spi_flash_front sfe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .so_oe(so_oe),
  .cmd_strobe(cmd_strobe), .cmd_id(cmd_id), .addr_valid(addr_valid),
  .wr_valid(wr_valid), .held(held), .locked(locked), .bit_cnt(bit_cnt)
);

// File: tb/sim_spi_flash_front.sv
module sim_spi_flash_front;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 4;
  localparam int AB         = 3;
  localparam int MAW        = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic [7:0] tx_byte;
  logic so, so_oe, cmd_strobe, addr_valid, wr_valid, rd_req;
  logic [3:0] cmd_id;
  logic [8*AB-1:0] addr;
  logic [7:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_front #(.ADDR_BYTES(AB), .MEM_AW(MAW)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .busy(busy), .status_in(status_in), .tx_byte(tx_byte),
    .so(so), .so_oe(so_oe), .cmd_strobe(cmd_strobe), .cmd_id(cmd_id),
    .addr_valid(addr_valid), .addr(addr), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    pat = a[7:0] ^ {4'h0, a[11:8]} ^ 8'h5A;
  endfunction
  assign tx_byte = pat(addr);

  function automatic logic [3:0] exp_id(input logic [7:0] op);
    case (op)
      8'h06: exp_id = 4'd1;  8'h04: exp_id = 4'd2;  8'h05: exp_id = 4'd3;
      8'h01: exp_id = 4'd4;  8'h03: exp_id = 4'd5;  8'h02: exp_id = 4'd6;
      8'h20: exp_id = 4'd7;  8'hD8: exp_id = 4'd8;  8'hC7: exp_id = 4'd9;
      default: exp_id = 4'd0;
    endcase
  endfunction

  int n_chk = 0, n_err = 0;
  int n_cmd = 0, n_addr = 0, n_wr = 0, n_rd = 0;
  logic [3:0]  last_id;
  logic [23:0] last_addr;
  logic [7:0]  wr_log [8];
  logic [23:0] wa_log [8];
  logic        oe_seen = 1'b0;
  logic        mode3 = 1'b0;

  always @(negedge clk) begin
    if (cmd_strobe) begin n_cmd++; last_id = cmd_id; end
    if (addr_valid) begin n_addr++; last_addr = addr; end
    if (wr_valid) begin
      wr_log[n_wr % 8] = wr_data; wa_log[n_wr % 8] = addr; n_wr++;
    end
    if (rd_req) n_rd++;
    if (so_oe) oe_seen = 1'b1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    sck = mode3; waitc(H); cs_n = 1'b0; oe_seen = 1'b0; waitc(H);
  endtask

  task automatic cs_hi();
    waitc(H); cs_n = 1'b1; sck = mode3; waitc(2*H);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      if (mode3) sck = 1'b0;
      si = tx[i];
      waitc(H);
      rx[i] = so;
      sck = 1'b1;
      waitc(H);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic xhold(input logic [7:0] tx, input int hb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 0; i--) begin
      if (i == hb) begin
        hold_n = 1'b0; waitc(H);
        check("R10 oe off in pause", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
          si = ~tx[i]; sck = 1'b1; waitc(H); sck = 1'b0; waitc(H);
        end
        check("R10 oe off after toggles", so_oe, 0);
        sck = 1'b1; waitc(H); hold_n = 1'b1; waitc(H);
        check("R10 release with sck high ignored", so_oe, 0);
        sck = 1'b0; waitc(H);
        check("R10 oe back after release", so_oe, 1);
      end
      si = tx[i]; waitc(H); rx[i] = so; sck = 1'b1; waitc(H); sck = 1'b0;
    end
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic read_run(input logic [23:0] start, input int n, input string tag);
    logic [7:0] d;
    int a0, r0;
    a0 = n_addr; r0 = n_rd;
    cs_lo(); xfer(8'h03, d); send_addr(start);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, d);
      check({tag, " R6 read byte"}, d, pat(24'((start + 24'(k)) & 24'hFFF)));
    end
    cs_hi();
    check({tag, " R5 addr strobe"}, n_addr - a0, 1);
    check({tag, " R5 masked addr"}, last_addr, start & 24'hFFF);
    check({tag, " R6 rd_req count"}, n_rd - r0, n + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    int c0, w0;
    logic [7:0] valid_ops [9];
    valid_ops = '{8'h06, 8'h04, 8'h05, 8'h01, 8'h03, 8'h02, 8'h20, 8'hD8, 8'hC7};
    waitc(5); rst_n = 1'b1; waitc(5);
    check("R1 reset so_oe", so_oe, 0);
    check("R1 reset strobes", {cmd_strobe, addr_valid, wr_valid, rd_req}, 0);

    // R2 R3 R12: full first-byte sweep in both modes
    for (int m = 0; m < 2; m++) begin
      mode3 = m[0];
      for (int op = 0; op < 256; op++) begin
        c0 = n_cmd; w0 = n_wr;
        cs_lo(); xfer(8'(op), d); xfer(8'hFF, d); cs_hi();
        if (exp_id(8'(op)) == 4'd0) begin
          check("R3 no strobe on bad byte", n_cmd - c0, 0);
          check("R3 no data after bad byte", {oe_seen, 8'(n_wr - w0)}, 0);
        end else begin
          check("R2 strobe count", n_cmd - c0, 1);
          check("R2 command id", last_id, exp_id(8'(op)));
          if (op == 8'h06 || op == 8'h04 || op == 8'hC7)
            check("R12 no output for plain command", oe_seen, 0);
        end
      end
    end
    mode3 = 1'b0;

    // R4 busy filter
    busy = 1'b1; status_in = 8'h81;
    for (int k = 0; k < 9; k++) begin
      c0 = n_cmd;
      cs_lo(); xfer(valid_ops[k], d); xfer(8'h00, d); cs_hi();
      check("R4 busy accepts only status read", n_cmd - c0, (valid_ops[k] == 8'h05) ? 1 : 0);
      if (valid_ops[k] == 8'h05) check("R4 status under busy", d, 8'h81);
    end
    busy = 1'b0;

    // R5 erase address
    c0 = n_addr;
    cs_lo(); xfer(8'h20, d); send_addr(24'h123456); cs_hi();
    check("R5 erase addr strobe", n_addr - c0, 1);
    check("R5 erase addr masked", last_addr, 24'h000456);

    // R6 read with wrap, both modes
    read_run(24'hABCFFE, 4, "m0");
    mode3 = 1'b1; read_run(24'h0007F0, 3, "m3"); mode3 = 1'b0;

    // R7 program with wrap
    w0 = n_wr;
    cs_lo(); xfer(8'h02, d); send_addr(24'h000FFF);
    xfer(8'hA1, d); xfer(8'hB2, d); xfer(8'hC3, d); cs_hi();
    check("R7 write count", n_wr - w0, 3);
    check("R7 byte0", {wa_log[w0 % 8], wr_log[w0 % 8]}, {24'h000FFF, 8'hA1});
    check("R7 byte1 wraps", {wa_log[(w0+1) % 8], wr_log[(w0+1) % 8]}, {24'h000000, 8'hB2});
    check("R7 byte2", {wa_log[(w0+2) % 8], wr_log[(w0+2) % 8]}, {24'h000001, 8'hC3});

    // R8 status write single byte
    w0 = n_wr;
    cs_lo(); xfer(8'h01, d); xfer(8'h3C, d); xfer(8'h77, d); cs_hi();
    check("R8 one write", n_wr - w0, 1);
    check("R8 write data", wr_log[w0 % 8], 8'h3C);

    // R9 status read repeats, mode 3
    mode3 = 1'b1; status_in = 8'hA5;
    cs_lo(); xfer(8'h05, d); xfer(8'h00, d); xfer(8'h00, d2); cs_hi();
    check("R9 status byte 0", d, 8'hA5);
    check("R9 status byte 1", d2, 8'hA5);
    check("R9 oe seen", oe_seen, 1);
    mode3 = 1'b0;

    // R10 pause inside a read byte
    cs_lo(); xfer(8'h03, d); send_addr(24'h0000A0);
    xfer(8'h00, d); check("R10 byte before pause", d, pat(24'h0A0));
    xhold(8'h00, 3, d); check("R10 byte across pause", d, pat(24'h0A1));
    xfer(8'h00, d); check("R10 byte after pause", d, pat(24'h0A2));
    cs_hi();

    // R11 deselect discards partial byte / partial address
    c0 = n_cmd;
    cs_lo(); xbits(8'h03, 5, d); cs_hi();
    cs_lo(); xfer(8'h06, d); cs_hi();
    check("R11 partial byte dropped", n_cmd - c0, 1);
    check("R11 next command decoded", last_id, 4'd1);
    c0 = n_addr;
    cs_lo(); xfer(8'h03, d); xfer(8'h01, d); cs_hi();
    cs_lo(); xfer(8'hD8, d); send_addr(24'h000321); cs_hi();
    check("R11 partial address dropped", n_addr - c0, 1);
    check("R11 fresh address", last_addr, 24'h000321);
    check("R1 idle oe", so_oe, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule